// File: doc/BRIEF.md
# Variable-Length Instruction Decoder

This block classifies one 16-bit instruction word of a small processor with sixteen general registers. The two top bits pick one of three encoding forms. The first form is a register form: an 8-bit opcode with two 4-bit register operands. The second is a short-immediate form: a 2-bit sub-operation, one register and an 8-bit unsigned immediate. The third is a conditional branch form: a 4-bit condition code and a 10-bit halfword offset. From the form the decoder extracts the operand fields, an operation code, and whether a 32-bit immediate word trails the opcode. That last result makes the instruction either 2 or 6 bytes long.

Encodings outside the defined set raise an illegal flag, and the operation code then takes a dedicated value. A valid strobe loads every result into an output register. The results appear one clock later with an output valid bit. The fetch unit uses the length to step its pointer and to collect the trailing word, and the execute stage uses the remaining fields. The decoder executes nothing and fetches nothing.

Top module: `ivd_decoder`

## Requirements
- R1: `form` reports 1 when insn[15] is 0, 2 when insn[15:14] is 2'b10, and 3 when insn[15:14] is 2'b11, whether or not the encoding is legal.
- R2: In form 1, `op` equals insn[14:8] (opcode 0x00..0x39 kept as is), `ra` equals insn[7:4], `rb` equals insn[3:0], and `imm8`, `cond` and `br_off` are 0.
- R3: In form 2, `op` equals 0x40 plus insn[13:12] (0 increment, 1 decrement, 2 read special register, 3 write special register), `ra` equals insn[11:8], `imm8` equals insn[7:0], and `rb`, `cond` and `br_off` are 0. Form 2 is never illegal.
- R4: In form 3, `cond` equals insn[13:10], `op` equals 0x50 plus the condition, and `br_off` is insn[9:0] taken as a signed halfword count, doubled and sign-extended to 32 bits. `ra`, `rb` and `imm8` are 0.
- R5: `has_imm` is 1 and `len_bytes` is 6 exactly for the form 1 opcodes 0x01, 0x03, 0x08, 0x09, 0x0C, 0x0D, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24, 0x30 and 0x36 through 0x39. Every other instruction gives `has_imm` 0 and `len_bytes` 2.
- R6: A form 1 opcode in 0x0F..0x18 or in 0x3A..0x7F, or a form 3 condition above 9, sets `illegal`. It also forces `op` to 0x7F, `len_bytes` to 2 and `has_imm` to 0.
- R7: `shift_op` is 1 only for the form 1 opcodes 0x27, 0x28 and 0x2D. For these the shift amount is the low 5 bits of register `rb`.
- R8: The results of a word presented with `in_valid` high appear at the outputs after the next rising clock edge, and `out_valid` is then 1. `out_valid` is 0 in any cycle after an edge at which `in_valid` was low.
- R9: While `in_valid` is low, every decoded output keeps its last value whatever `insn` carries.
- R10: A synchronous reset (`rst` high at a rising edge) clears `out_valid` and every decoded output to 0, and it overrides `in_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe: load `insn` into the decoder |
| insn | input | 16 | Instruction word |
| out_valid | output | 1 | Registered results are from a strobed word |
| op | output | 7 | Operation code (see R2 to R4, R6) |
| form | output | 2 | Encoding form 1, 2 or 3 (0 after reset) |
| ra | output | 4 | First register index |
| rb | output | 4 | Second register index |
| imm8 | output | 8 | Short unsigned immediate |
| cond | output | 4 | Branch condition code |
| br_off | output | 32 | Sign-extended branch byte offset |
| has_imm | output | 1 | A 32-bit immediate word follows |
| len_bytes | output | 3 | Instruction length, 2 or 6 |
| illegal | output | 1 | Undefined encoding |
| shift_op | output | 1 | Shift operation: amount is the low 5 bits of `rb` |

## Verification
Every decoded result, and `out_valid` with them, is due exactly one rising edge after the word is strobed. The bench changes `insn` and `in_valid` on a falling edge and checks on the following falling edge, which lies after the single capturing edge and before the next. The hold test drops the strobe and changes `insn` at the same time, then checks one falling edge later that nothing moved. The reset tests check one falling edge after an edge with `rst` high.

// File: rtl/ivd_pkg.sv
package ivd_pkg;

  localparam int OP_W = 7;

  typedef logic [OP_W-1:0] op_t;

  typedef enum logic [1:0] {
    FORM_NONE   = 2'd0,
    FORM_REG    = 2'd1,
    FORM_IMM8   = 2'd2,
    FORM_BRANCH = 2'd3
  } form_e;

  localparam op_t OP_IMM8_BASE = 7'h40;
  localparam op_t OP_BR_BASE   = 7'h50;
  localparam op_t OP_ILLEGAL   = 7'h7F;
  localparam logic [3:0] COND_MAX = 4'd9;

  // register-form opcodes that are defined
  function automatic logic f_reg_legal(input logic [7:0] opc);
    return (opc <= 8'h0E) || ((opc >= 8'h19) && (opc <= 8'h39));
  endfunction

  // register-form opcodes carrying a trailing 32-bit word
  function automatic logic f_reg_long(input logic [7:0] opc);
    logic hit;
    case (opc)
      8'h01, 8'h03, 8'h08, 8'h09, 8'h0C, 8'h0D,
      8'h1A, 8'h1B, 8'h1D, 8'h1F,
      8'h20, 8'h22, 8'h24, 8'h30,
      8'h36, 8'h37, 8'h38, 8'h39: hit = 1'b1;
      default:                    hit = 1'b0;
    endcase
    return hit;
  endfunction

  // shifts: amount taken from low 5 bits of second register
  function automatic logic f_reg_shift(input logic [7:0] opc);
    return (opc == 8'h27) || (opc == 8'h28) || (opc == 8'h2D);
  endfunction

  function automatic form_e f_form(input logic [1:0] top2);
    form_e f;
    if (!top2[1])     f = FORM_REG;
    else if (!top2[0]) f = FORM_IMM8;
    else              f = FORM_BRANCH;
    return f;
  endfunction

endpackage

// File: rtl/ivd_classify.sv
module ivd_classify
  import ivd_pkg::*;
#(
  parameter int LEN_W     = 3,
  parameter int LEN_SHORT = 2,
  parameter int LEN_LONG  = 6
) (
  input  logic [7:0]       hi,
  output form_e            form,
  output op_t              op,
  output logic             legal,
  output logic             has_imm,
  output logic [LEN_W-1:0] len_bytes,
  output logic             shift_op
);

  logic [1:0] sub_op;
  logic [3:0] cond_code;

  assign form      = f_form(hi[7:6]);
  assign sub_op    = hi[5:4];
  assign cond_code = hi[5:2];

  always_comb begin
    legal = 1'b1;
    op    = OP_ILLEGAL;
    unique case (form)
      FORM_REG: begin
        legal = f_reg_legal(hi);
        op    = hi[6:0];
      end
      FORM_IMM8: begin
        op = OP_IMM8_BASE | op_t'(sub_op);
      end
      FORM_BRANCH: begin
        legal = (cond_code <= COND_MAX);
        op    = OP_BR_BASE | op_t'(cond_code);
      end
      default: legal = 1'b0;
    endcase
    if (!legal) op = OP_ILLEGAL;
  end

  assign has_imm   = (form == FORM_REG) && legal && f_reg_long(hi);
  assign len_bytes = has_imm ? LEN_W'(LEN_LONG) : LEN_W'(LEN_SHORT);
  assign shift_op  = (form == FORM_REG) && f_reg_shift(hi);

endmodule

// File: rtl/ivd_fields.sv
module ivd_fields
  import ivd_pkg::*;
#(
  parameter int REG_W  = 4,
  parameter int IMM_W  = 8,
  parameter int COND_W = 4,
  parameter int OFF_W  = 10,
  parameter int ADDR_W = 32,
  localparam int BODY_W = OFF_W + COND_W
) (
  input  logic [BODY_W-1:0] body,
  input  form_e             form,
  output logic [REG_W-1:0]  ra,
  output logic [REG_W-1:0]  rb,
  output logic [IMM_W-1:0]  imm8,
  output logic [COND_W-1:0] cond,
  output logic [ADDR_W-1:0] br_off
);

  localparam int EXT_W = ADDR_W - OFF_W - 1;

  logic [OFF_W-1:0]  off_raw;
  logic [ADDR_W-1:0] off_bytes;

  assign off_raw   = body[OFF_W-1:0];
  // halfword count -> signed byte offset
  assign off_bytes = {{EXT_W{off_raw[OFF_W-1]}}, off_raw, 1'b0};

  always_comb begin
    ra     = '0;
    rb     = '0;
    imm8   = '0;
    cond   = '0;
    br_off = '0;
    unique case (form)
      FORM_REG: begin
        ra = body[2*REG_W-1:REG_W];
        rb = body[REG_W-1:0];
      end
      FORM_IMM8: begin
        ra   = body[IMM_W+REG_W-1:IMM_W];
        imm8 = body[IMM_W-1:0];
      end
      FORM_BRANCH: begin
        cond   = body[BODY_W-1:OFF_W];
        br_off = off_bytes;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ivd_stage.sv
module ivd_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         q_valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q       <= '0;
      q_valid <= 1'b0;
    end else begin
      q_valid <= load;
      if (load) q <= d;
    end
  end

endmodule

// File: rtl/ivd_decoder.sv
module ivd_decoder
  import ivd_pkg::*;
#(
  parameter int INSN_W = 16,
  parameter int REG_W  = 4,
  parameter int IMM_W  = 8,
  parameter int COND_W = 4,
  parameter int OFF_W  = 10,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] insn,
  output logic              out_valid,
  output logic [OP_W-1:0]   op,
  output logic [1:0]        form,
  output logic [REG_W-1:0]  ra,
  output logic [REG_W-1:0]  rb,
  output logic [IMM_W-1:0]  imm8,
  output logic [COND_W-1:0] cond,
  output logic [ADDR_W-1:0] br_off,
  output logic              has_imm,
  output logic [LEN_W-1:0]  len_bytes,
  output logic              illegal,
  output logic              shift_op
);

  localparam int BODY_W = OFF_W + COND_W;
  localparam int PAY_W  = OP_W + 2 + 2*REG_W + IMM_W + COND_W + ADDR_W + LEN_W + 3;

  // named decode events, visible to the checker
  form_e             dec_form;
  op_t               dec_op;
  logic              dec_legal;
  logic              dec_long;
  logic              dec_shift;
  logic [LEN_W-1:0]  dec_len;
  logic [REG_W-1:0]  dec_ra, dec_rb;
  logic [IMM_W-1:0]  dec_imm;
  logic [COND_W-1:0] dec_cond;
  logic [ADDR_W-1:0] dec_off;
  logic [PAY_W-1:0]  pay_d, pay_q;

  ivd_classify #(.LEN_W(LEN_W)) u_cls (
    .hi        (insn[INSN_W-1:INSN_W-8]),
    .form      (dec_form),
    .op        (dec_op),
    .legal     (dec_legal),
    .has_imm   (dec_long),
    .len_bytes (dec_len),
    .shift_op  (dec_shift)
  );

  ivd_fields #(
    .REG_W(REG_W), .IMM_W(IMM_W), .COND_W(COND_W),
    .OFF_W(OFF_W), .ADDR_W(ADDR_W)
  ) u_fld (
    .body   (insn[BODY_W-1:0]),
    .form   (dec_form),
    .ra     (dec_ra),
    .rb     (dec_rb),
    .imm8   (dec_imm),
    .cond   (dec_cond),
    .br_off (dec_off)
  );

  assign pay_d = {dec_op, dec_form, dec_ra, dec_rb, dec_imm, dec_cond,
                  dec_off, dec_len, dec_long, !dec_legal, dec_shift};

  ivd_stage #(.W(PAY_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .load    (in_valid),
    .d       (pay_d),
    .q       (pay_q),
    .q_valid (out_valid)
  );

  assign {op, form, ra, rb, imm8, cond, br_off,
          len_bytes, has_imm, illegal, shift_op} = pay_q;

endmodule

// File: rtl/ivd_decoder_chk.sv
module ivd_decoder_chk #(
  parameter int REG_W  = 4,
  parameter int COND_W = 4,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              out_valid,
  input logic [6:0]        op,
  input logic [1:0]        form,
  input logic [REG_W-1:0]  ra,
  input logic [REG_W-1:0]  rb,
  input logic [COND_W-1:0] cond,
  input logic [ADDR_W-1:0] br_off,
  input logic              has_imm,
  input logic [LEN_W-1:0]  len_bytes,
  input logic              illegal,
  input logic              shift_op
);

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r8_valid_drops: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(op) && $stable(ra) && $stable(rb) &&
                   $stable(br_off) && $stable(len_bytes) && $stable(illegal)));

  a_r6_illegal_shape: assert property (@(posedge clk) disable iff (rst)
    (out_valid && illegal) |-> (op == 7'h7F && len_bytes == LEN_W'(2) && !has_imm));

  a_r5_long_only_reg_form: assert property (@(posedge clk) disable iff (rst)
    has_imm |-> (form == 2'd1 && len_bytes == LEN_W'(6)));

  a_r3_imm8_form_legal: assert property (@(posedge clk) disable iff (rst)
    (out_valid && form == 2'd2) |-> (!illegal && rb == '0 && cond == '0));

  a_r7_shift_short: assert property (@(posedge clk) disable iff (rst)
    shift_op |-> (form == 2'd1 && !has_imm && !illegal));

  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && op == 7'h00 && form == 2'd0));

endmodule

bind ivd_decoder ivd_decoder_chk #(
  .REG_W(REG_W), .COND_W(COND_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .op(op), .form(form), .ra(ra), .rb(rb), .cond(cond), .br_off(br_off),
  .has_imm(has_imm), .len_bytes(len_bytes), .illegal(illegal),
  .shift_op(shift_op)
);

// File: tb/tb_ivd_decoder.sv
module tb_ivd_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 22;

  // {insn, expected op, expected length}
  localparam logic [31:0] VEC [NVEC] = '{
    {16'h0000, 8'h00, 8'd2}, {16'h0123, 8'h01, 8'd6},
    {16'h0345, 8'h03, 8'd6}, {16'h0E12, 8'h0E, 8'd2},
    {16'h0F00, 8'h7F, 8'd2}, {16'h1800, 8'h7F, 8'd2},
    {16'h1934, 8'h19, 8'd2}, {16'h1A00, 8'h1A, 8'd6},
    {16'h2745, 8'h27, 8'd2}, {16'h2D00, 8'h2D, 8'd2},
    {16'h3900, 8'h39, 8'd6}, {16'h3A00, 8'h7F, 8'd2},
    {16'h7F00, 8'h7F, 8'd2}, {16'h85AB, 8'h40, 8'd2},
    {16'h9C01, 8'h41, 8'd2}, {16'hA3FF, 8'h42, 8'd2},
    {16'hB010, 8'h43, 8'd2}, {16'hC000, 8'h50, 8'd2},
    {16'hE5FF, 8'h59, 8'd2}, {16'hE800, 8'h7F, 8'd2},
    {16'hC200, 8'h50, 8'd2}, {16'hFFFF, 8'h7F, 8'd2}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] insn = 16'h0;
  logic        out_valid;
  logic [6:0]  op;
  logic [1:0]  form;
  logic [3:0]  ra, rb, cond;
  logic [7:0]  imm8;
  logic [31:0] br_off;
  logic        has_imm, illegal, shift_op;
  logic [2:0]  len_bytes;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ivd_decoder dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
    .out_valid(out_valid), .op(op), .form(form), .ra(ra), .rb(rb),
    .imm8(imm8), .cond(cond), .br_off(br_off), .has_imm(has_imm),
    .len_bytes(len_bytes), .illegal(illegal), .shift_op(shift_op)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int e_form(input logic [15:0] i);
    if (i[15] == 1'b0) return 1;
    return i[14] ? 3 : 2;
  endfunction

  function automatic int e_ra(input logic [15:0] i);
    case (e_form(i))
      1: return (i >> 4) & 15;
      2: return (i >> 8) & 15;
      default: return 0;
    endcase
  endfunction

  function automatic int e_rb(input logic [15:0] i);
    return (e_form(i) == 1) ? (i & 15) : 0;
  endfunction

  function automatic int e_imm8(input logic [15:0] i);
    return (e_form(i) == 2) ? (i & 255) : 0;
  endfunction

  function automatic int e_cond(input logic [15:0] i);
    return (e_form(i) == 3) ? ((i >> 10) & 15) : 0;
  endfunction

  function automatic logic [31:0] e_off(input logic [15:0] i);
    int v;
    if (e_form(i) != 3) return 32'h0;
    v = i & 1023;
    if (v >= 512) v = v - 1024;
    return 32'(v * 2);
  endfunction

  function automatic logic e_shift(input logic [15:0] i);
    int opc;
    opc = i >> 8;
    return (e_form(i) == 1) && (opc == 39 || opc == 40 || opc == 45);
  endfunction

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [6:0] held_op;
    logic [31:0] held_off;

    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10", "out_valid after reset", 32'(out_valid), 32'h0);
    chk("R10", "op after reset", 32'(op), 32'h0);
    chk("R10", "form after reset", 32'(form), 32'h0);
    rst = 1'b0;

    // table walk: strobe on a falling edge, check one falling edge later
    for (int k = 0; k < NVEC; k++) begin
      logic [15:0] w;
      logic [7:0]  xop, xlen;
      w    = VEC[k][31:16];
      xop  = VEC[k][15:8];
      xlen = VEC[k][7:0];
      insn = w;
      in_valid = 1'b1;
      @(negedge clk);
      chk("R8", $sformatf("out_valid %h", w), 32'(out_valid), 32'h1);
      chk("R1", $sformatf("form %h", w), 32'(form), 32'(e_form(w)));
      chk("R2", $sformatf("op %h", w), 32'(op), 32'(xop[6:0]));
      chk("R5", $sformatf("len %h", w), 32'(len_bytes), 32'(xlen));
      chk("R5", $sformatf("has_imm %h", w), 32'(has_imm), 32'(xlen == 8'd6));
      chk("R6", $sformatf("illegal %h", w), 32'(illegal), 32'(xop == 8'h7F));
      chk("R2", $sformatf("ra %h", w), 32'(ra), 32'(e_ra(w)));
      chk("R2", $sformatf("rb %h", w), 32'(rb), 32'(e_rb(w)));
      chk("R3", $sformatf("imm8 %h", w), 32'(imm8), 32'(e_imm8(w)));
      chk("R4", $sformatf("cond %h", w), 32'(cond), 32'(e_cond(w)));
      chk("R4", $sformatf("br_off %h", w), br_off, e_off(w));
      chk("R7", $sformatf("shift_op %h", w), 32'(shift_op), 32'(e_shift(w)));
    end

    // R4 boundary offsets stated outright
    insn = 16'hC1FF; in_valid = 1'b1;
    @(negedge clk);
    chk("R4", "max positive offset", br_off, 32'h0000_03FE);
    insn = 16'hC3FF;
    @(negedge clk);
    chk("R4", "offset minus one", br_off, 32'hFFFF_FFFE);

    // R9: strobe low, insn changes, outputs hold
    held_op  = op;
    held_off = br_off;
    insn = 16'h0123; in_valid = 1'b0;
    @(negedge clk);
    chk("R8", "out_valid without strobe", 32'(out_valid), 32'h0);
    chk("R9", "op held", 32'(op), 32'(held_op));
    chk("R9", "br_off held", br_off, held_off);
    chk("R9", "len held", 32'(len_bytes), 32'd2);
    insn = 16'h85AB;
    @(negedge clk);
    chk("R9", "form held", 32'(form), 32'd3);

    // R10: reset overrides strobe
    insn = 16'h0123; in_valid = 1'b1;
    @(negedge clk);
    chk("R5", "long op before reset", 32'(len_bytes), 32'd6);
    rst = 1'b1;
    @(negedge clk);
    chk("R10", "out_valid under reset", 32'(out_valid), 32'h0);
    chk("R10", "len under reset", 32'(len_bytes), 32'h0);
    chk("R10", "ra under reset", 32'(ra), 32'h0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule